// File: doc/BRIEF.md
# Dual-Window Gated Photon Counter

This block counts photon detections from a 10×10 array of single-photon detectors, but only during two short time windows that follow each laser pulse. The detector outputs pass through a per-cell enable mask and are then merged into one event stream. A laser-sync pulse starts the window sequence. Window one lasts a programmable number of fast-clock ticks. Window two opens on the tick after window one closes and lasts its own programmable number of ticks. Each window has its own 10-bit saturating counter.

The counts are double-buffered. A frame-swap strobe moves the running counts into a held readout set and restarts counting from zero. Software can read one frame's counts while the next frame is being acquired. The mask is written one cell at a time. This lets cells with a high dark-count rate be switched off.

Top module: `gated_photon_counter`

## Requirements
- R1: After synchronous reset, both count outputs are 0, all 100 cells are enabled and no window is open.
- R2: When sync_i is high in cycle t, window one is open in cycles t+1 to t+W1. Window two is open in cycles t+W1+1 to t+W1+W2. An event in a given cycle goes to the window that is open in that same cycle.
- R3: The width codes are captured in the sync cycle. A code of 0 acts as 1 and a code above 20 acts as 20. Changing a code mid-sequence has no effect on the running sequence.
- R4: A cycle in which one or more enabled cells fire adds exactly 1 to the open window's counter.
- R5: A write with mask_we_i high sets the enable bit of cell mask_addr_i (0 to 99) to mask_wdata_i, where 0 means disabled. The new value applies from the next cycle. Events from a disabled cell are not counted.
- R6: Events in cycles when neither window is open do not change either count.
- R7: Each counter stops at 1023 and does not wrap.
- R8: When swap_i is high in cycle s, from cycle s+1 the outputs show the counts including any event in cycle s. Counting then restarts from 0.
- R9: Without a swap, cnt1_o and cnt2_o keep their value.
- R10: A sync pulse that arrives while a window is open restarts the sequence at window one. The event in the sync cycle still counts toward the window that was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is one window step |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Laser-sync pulse, one tick |
| det_i | input | 100 | Synchronized single-tick detector events, one per cell |
| mask_we_i | input | 1 | Enable-mask write strobe |
| mask_addr_i | input | 7 | Cell index for the mask write |
| mask_wdata_i | input | 1 | Enable value to write (1 = enabled) |
| w1_code_i | input | 5 | Window-one width in ticks |
| w2_code_i | input | 5 | Window-two width in ticks |
| swap_i | input | 1 | Frame swap: publish counts and restart counting |
| cnt1_o | output | 10 | Held window-one count of the last frame |
| cnt2_o | output | 10 | Held window-two count of the last frame |

## Verification
The bench targets the window edges. These are the sync cycle itself, the last tick of window one and the first tick of window two. A design that is off by one register would leak a count into the wrong window or drop the boundary tick. The bench also drives width codes 0 and 25, and changes a code mid-sequence. An unclamped or unlatched width would then give a count of 0 or 25 instead of 1 and 20.

Further runs drive a frame long enough to pass 1023 counts, which a wrapping counter would fold back to a small value. Other runs swap with an event in the swap cycle, which a design that loses that event would report one short. A sync inside an open window checks that the sequence restarts rather than running to its first end. A disabled cell firing inside a window must leave the counts unchanged.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_W1, PH_W2} gpc_phase_t;
endpackage

// File: rtl/gpc_cell_merge.sv
module gpc_cell_merge #(
  parameter int N_CELLS = 100,
  parameter int AW      = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic               wdata_i,
  input  logic [N_CELLS-1:0] det_i,
  output logic               hit_o
);
  logic [N_CELLS-1:0] en_q;

  // one enable flop per cell so that all cells can be gated in parallel
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)                                  en_q[i] <= 1'b1;
      else if (we_i && addr_i == AW'(i))        en_q[i] <= wdata_i;
    end
  end

  assign hit_o = |(det_i & en_q);
endmodule

// File: rtl/gpc_window_gen.sv
module gpc_window_gen
  import gpc_pkg::*;
#(
  parameter int W_MAX = 20,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  input  logic [CW-1:0] w1_i,
  input  logic [CW-1:0] w2_i,
  output logic          win1_o,
  output logic          win2_o
);
  localparam logic [CW-1:0] CMAX = CW'(W_MAX);
  localparam logic [CW-1:0] CONE = CW'(1);

  gpc_phase_t    ph;
  logic [CW-1:0] rem;
  logic [CW-1:0] w2_lat;

  function automatic logic [CW-1:0] fit(input logic [CW-1:0] c);
    if (c == '0)   return CONE;
    if (c > CMAX)  return CMAX;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      rem    <= '0;
      w2_lat <= CONE;
    end else if (sync_i) begin
      ph     <= PH_W1;
      rem    <= fit(w1_i) - CONE;
      w2_lat <= fit(w2_i);
    end else begin
      case (ph)
        PH_W1: begin
          if (rem == '0) begin
            ph  <= PH_W2;
            rem <= w2_lat - CONE;
          end else begin
            rem <= rem - CONE;
          end
        end
        PH_W2: begin
          if (rem == '0) ph <= PH_IDLE;
          else           rem <= rem - CONE;
        end
        default: ;
      endcase
    end
  end

  assign win1_o = (ph == PH_W1);
  assign win2_o = (ph == PH_W2);
endmodule

// File: rtl/gpc_bank.sv
module gpc_bank #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             swap_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] rd_o
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] nxt;
  assign nxt = (inc_i && acc_o != TOP) ? acc_o + CNT_W'(1) : acc_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
      rd_o  <= '0;
    end else if (swap_i) begin
      rd_o  <= nxt;
      acc_o <= '0;
    end else begin
      acc_o <= nxt;
    end
  end
endmodule

// File: rtl/gated_photon_counter.sv
module gated_photon_counter #(
  parameter int N_CELLS = 100,
  parameter int CNT_W   = 10,
  parameter int W_MAX   = 20,
  localparam int AW     = $clog2(N_CELLS),
  localparam int CW     = $clog2(W_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_i,
  input  logic [N_CELLS-1:0] det_i,
  input  logic               mask_we_i,
  input  logic [AW-1:0]      mask_addr_i,
  input  logic               mask_wdata_i,
  input  logic [CW-1:0]      w1_code_i,
  input  logic [CW-1:0]      w2_code_i,
  input  logic               swap_i,
  output logic [CNT_W-1:0]   cnt1_o,
  output logic [CNT_W-1:0]   cnt2_o
);
  logic             hit;
  logic             win1, win2;
  logic [1:0]       inc;
  logic [CNT_W-1:0] acc [2];
  logic [CNT_W-1:0] rd  [2];

  gpc_cell_merge #(.N_CELLS(N_CELLS), .AW(AW)) u_merge (
    .clk(clk), .rst(rst), .we_i(mask_we_i), .addr_i(mask_addr_i),
    .wdata_i(mask_wdata_i), .det_i(det_i), .hit_o(hit)
  );

  gpc_window_gen #(.W_MAX(W_MAX), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .sync_i(sync_i), .w1_i(w1_code_i),
    .w2_i(w2_code_i), .win1_o(win1), .win2_o(win2)
  );

  assign inc = {hit & win2, hit & win1};

  for (genvar g = 0; g < 2; g++) begin : g_bank
    gpc_bank #(.CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst(rst), .inc_i(inc[g]), .swap_i(swap_i),
      .acc_o(acc[g]), .rd_o(rd[g])
    );
  end

  assign cnt1_o = rd[0];
  assign cnt2_o = rd[1];
endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_i,
  input logic             swap_i,
  input logic             win1,
  input logic             win2,
  input logic [CNT_W-1:0] acc1,
  input logic [CNT_W-1:0] acc2,
  input logic [CNT_W-1:0] cnt1_o,
  input logic [CNT_W-1:0] cnt2_o
);
  p_sync_opens_w1_r2: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (win1 && !win2));

  p_one_window_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({win1, win2}));

  p_closed_no_count_r6: assert property (@(posedge clk) disable iff (rst)
    (!win1 && !win2 && !swap_i) |=> ($stable(acc1) && $stable(acc2)));

  p_saturate_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (acc1 == '1 && !swap_i) |=> (acc1 == '1));

  p_saturate_hold2_r7: assert property (@(posedge clk) disable iff (rst)
    (acc2 == '1 && !swap_i) |=> (acc2 == '1));

  p_clear_on_swap_r8: assert property (@(posedge clk) disable iff (rst)
    swap_i |=> (acc1 == '0 && acc2 == '0));

  p_out_stable_r9: assert property (@(posedge clk) disable iff (rst)
    !swap_i |=> ($stable(cnt1_o) && $stable(cnt2_o)));
endmodule

bind gated_photon_counter gpc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sync_i(sync_i), .swap_i(swap_i),
  .win1(win1), .win2(win2), .acc1(acc[0]), .acc2(acc[1]),
  .cnt1_o(cnt1_o), .cnt2_o(cnt2_o)
);

// File: tb/gated_photon_counter_tb.sv
`timescale 1ns/1ps
module gated_photon_counter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        sync_i, mask_we_i, mask_wdata_i, swap_i;
  logic [99:0] det_i;
  logic [6:0]  mask_addr_i;
  logic [4:0]  w1_code_i, w2_code_i;
  logic [9:0]  cnt1_o, cnt2_o;

  int    total = 0, bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #10 clk = ~clk;

  gated_photon_counter u_dut (
    .clk(clk), .rst(rst), .sync_i(sync_i), .det_i(det_i),
    .mask_we_i(mask_we_i), .mask_addr_i(mask_addr_i), .mask_wdata_i(mask_wdata_i),
    .w1_code_i(w1_code_i), .w2_code_i(w2_code_i), .swap_i(swap_i),
    .cnt1_o(cnt1_o), .cnt2_o(cnt2_o)
  );

  // behavioural reference: windows as offsets from the last sync cycle
  int cyc = 0, ts = -1000, len1 = 1, len2 = 1;
  int m_a1 = 0, m_a2 = 0, m_r1 = 0, m_r2 = 0;
  bit m_en [100];
  bit m_started = 1'b0;

  function automatic int fitw(input int c);
    if (c == 0) return 1;
    if (c > 20) return 20;
    return c;
  endfunction

  always @(posedge clk) begin
    int d, win;
    bit hit;
    cyc++;
    if (rst) begin
      ts = -1000; m_a1 = 0; m_a2 = 0; m_r1 = 0; m_r2 = 0;
      foreach (m_en[i]) m_en[i] = 1'b1;
      m_started = 1'b1;
    end else begin
      hit = 1'b0;
      for (int i = 0; i < 100; i++) if (det_i[i] && m_en[i]) hit = 1'b1;
      d = cyc - ts;
      win = 0;
      if (d >= 1 && d <= len1) win = 1;
      else if (d > len1 && d <= len1 + len2) win = 2;
      if (hit && win == 1 && m_a1 < 1023) m_a1++;
      if (hit && win == 2 && m_a2 < 1023) m_a2++;
      if (swap_i) begin
        m_r1 = m_a1; m_r2 = m_a2; m_a1 = 0; m_a2 = 0;
      end
      if (sync_i) begin
        ts = cyc; len1 = fitw(int'(w1_code_i)); len2 = fitw(int'(w2_code_i));
      end
      if (mask_we_i && mask_addr_i < 100) m_en[mask_addr_i] = mask_wdata_i;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (m_started && !done) begin
      check(cur_req, "cnt1 vs model", int'(cnt1_o), m_r1);
      check(cur_req, "cnt2 vs model", int'(cnt2_o), m_r2);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_swap();
    swap_i = 1'b1; step(1); swap_i = 1'b0;
  endtask

  task automatic start(input int a, input int b);
    w1_code_i = 5'(a); w2_code_i = 5'(b); sync_i = 1'b1; step(1); sync_i = 1'b0;
  endtask

  task automatic mask_write(input int a, input bit v);
    mask_we_i = 1'b1; mask_addr_i = 7'(a); mask_wdata_i = v; step(1); mask_we_i = 1'b0;
  endtask

  initial begin
    rst = 1'b1; sync_i = 0; det_i = '0; mask_we_i = 0; mask_addr_i = '0;
    mask_wdata_i = 0; w1_code_i = 5'd1; w2_code_i = 5'd1; swap_i = 0;
    step(3);
    rst = 1'b0;
    check("R1", "cnt1 reset", int'(cnt1_o), 0);
    check("R1", "cnt2 reset", int'(cnt2_o), 0);

    // R2: 3 + 2 tick windows, events on every tick
    cur_req = "R2";
    det_i[5] = 1'b1; start(3, 2); step(8); det_i = '0;
    do_swap();
    check("R2", "w1 count", int'(cnt1_o), 3);
    check("R2", "w2 count", int'(cnt2_o), 2);

    // R3: code 0 -> 1, code 25 -> 20, mid-sequence code change ignored
    cur_req = "R3";
    det_i[3] = 1'b1; start(0, 25); w1_code_i = 5'd7; w2_code_i = 5'd2;
    step(30); det_i = '0;
    do_swap();
    check("R3", "w1 clamp low", int'(cnt1_o), 1);
    check("R3", "w2 clamp high", int'(cnt2_o), 20);

    // R4 and R1: all cells firing together count once per tick
    cur_req = "R4";
    det_i = '1; start(4, 4); step(12); det_i = '0;
    do_swap();
    check("R4", "merged w1", int'(cnt1_o), 4);
    check("R4", "merged w2", int'(cnt2_o), 4);

    // R6: events only outside the windows (sync cycle and after close)
    cur_req = "R6";
    det_i[9] = 1'b1; start(2, 2); det_i = '0; step(4);
    det_i[9] = 1'b1; step(8); det_i = '0;
    do_swap();
    check("R6", "w1 outside", int'(cnt1_o), 0);
    check("R6", "w2 outside", int'(cnt2_o), 0);

    // R10: second sync inside window one restarts the sequence
    cur_req = "R10";
    det_i[1] = 1'b1; start(5, 2); step(2); start(5, 2); step(12); det_i = '0;
    do_swap();
    check("R10", "w1 restart", int'(cnt1_o), 8);
    check("R10", "w2 restart", int'(cnt2_o), 2);

    // R8: swap inside an open window, event in the swap cycle counted
    cur_req = "R8";
    det_i[2] = 1'b1; start(6, 1); step(2); do_swap();
    check("R8", "w1 at mid swap", int'(cnt1_o), 3);
    check("R8", "w2 at mid swap", int'(cnt2_o), 0);
    step(6); det_i = '0;
    do_swap();
    check("R8", "w1 after restart", int'(cnt1_o), 3);
    check("R8", "w2 after restart", int'(cnt2_o), 1);
    do_swap();
    check("R8", "w1 empty frame", int'(cnt1_o), 0);

    // R5: disabled cell 5 ignored, cell 7 counted, re-enable works
    cur_req = "R5";
    mask_write(5, 1'b0);
    det_i[5] = 1'b1; start(5, 5); step(12); det_i = '0;
    do_swap();
    check("R5", "masked cell w1", int'(cnt1_o), 0);
    check("R5", "masked cell w2", int'(cnt2_o), 0);
    start(5, 5); det_i[7] = 1'b1; step(2); det_i[7] = 1'b0;
    mask_write(5, 1'b1); step(3); det_i[5] = 1'b1; step(1); det_i = '0; step(6);
    do_swap();
    check("R5", "enabled cell w1", int'(cnt1_o), 2);
    check("R5", "re-enabled cell w2", int'(cnt2_o), 1);

    // R7: 55 frames of 20 + 1 ticks -> window one saturates
    cur_req = "R7";
    det_i[0] = 1'b1;
    for (int f = 0; f < 55; f++) begin
      start(20, 1); step(21);
    end
    det_i = '0;
    do_swap();
    check("R7", "w1 saturated", int'(cnt1_o), 1023);
    check("R7", "w2 count", int'(cnt2_o), 55);

    // R9: a counting frame without swap leaves the outputs alone
    cur_req = "R9";
    det_i[4] = 1'b1; start(6, 6); step(14); det_i = '0;
    check("R9", "w1 held", int'(cnt1_o), 1023);
    check("R9", "w2 held", int'(cnt2_o), 55);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule